// File: doc/BRIEF.md
# Indexed Block Register Target for a Two-Wire Bus

This block is a target on an SMBus/I2C style two-wire bus. It keeps a small control register file, eight bytes by default, whose contents drive downstream control logic through a parallel output. Every bus access is a block access. A write names a starting index and a byte count, then sends the data bytes. A read first sets the index with a short write. It then issues a repeated start with the read address. The target answers with the stored byte count and then the register bytes, beginning at that index.

SCL and SDA are open-drain lines. The block samples them with a faster system clock through two-flop synchronisers. It finds start and stop conditions as SDA edges while SCL is high. It only pulls SDA low, and it changes SDA only while SCL is low. Most bits can be written. A few bits are read-only and come from input ports: three latched frequency-select straps and an identification byte. Clock stretching and packet error checking are not supported.

Top module: `smbIndexTarget`

## Requirements
- R1: After reset the output bytes 0 and 2 read 0xFF, byte 1 reads 0xFE (its bit 0 is the spread enable, cleared), bytes 3 to 5 read 0x00, and the writable bits 7:3 of byte 6 read 0. Byte k sits at ctlOut[8k+7:8k]. SDA is released.
- R2: Only the 8-bit address 0xD2 (write) or 0xD3 (read) is acknowledged. After any other address the target leaves SDA released and ignores the bus until the next start or stop.
- R3: A write sends 0xD2, index N, count X and then data bytes. The target acknowledges each byte and stores data byte k into register N+k.
- R4: A read sends 0xD2 and index N, then a repeated start and 0xD3. The target returns the stored count X first, then registers N, N+1, and so on, one for each byte the host acknowledges.
- R5: A read of an index above 7 returns 0x00. A write to an index above 7 is acknowledged but changes no register.
- R6: Byte 6 bits 2:0 always show fsSel and byte 7 always shows devId, both on ctlOut and on reads. Writes to these bits have no effect.
- R7: Data bytes beyond the declared count are acknowledged but not stored.
- R8: A host NACK ends a read. SDA then stays released until the next start.
- R9: A stop in the middle of a write keeps every data byte that was already acknowledged.
- R10: The target changes SDA only while SCL is low, and the writable register bits change only while SCL is low.
- R11: The stored count is 8 after reset and is replaced by the count of each later write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, several times faster than SCL |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | SCL line level |
| sdaIn | input | 1 | SDA line level |
| sdaOe | output | 1 | 1 pulls SDA low |
| fsSel | input | 3 | Latched frequency-select straps, read-only in byte 6 bits 2:0 |
| devId | input | 8 | Identification byte, read-only as byte 7 |
| ctlOut | output | 64 | Register view, byte k at bits 8k+7:8k |

## Verification
The timing is counted from the SCL falling edge that ends a byte. SDA for an acknowledge or a read bit changes three system clocks after that edge, and a register write reaches ctlOut one clock later still. SCL holds each level for eight clocks. The bench therefore samples SDA halfway through the SCL high phase, well after the value has settled. It reads ctlOut only after a stop, many clocks after the last commit. The checker requires that SDA edges and register changes happen only while SCL is low.

// File: rtl/smbPkg.sv
package smbPkg;
  typedef enum logic [2:0] {
    stIdle, stAddr, stIndex, stCount, stWrData, stRdData, stIgnore
  } busState_t;

  typedef struct packed {
    logic       setIndex;
    logic       setCount;
    logic       putByte;
    logic       advance;
    logic [7:0] data;
  } dpStrobe_t;
endpackage

// File: rtl/smbCtrl.sv
module smbCtrl
  import smbPkg::*;
#(
  parameter logic [6:0] ADDR7 = 7'h69
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      sclIn,
  input  logic      sdaIn,
  input  logic [7:0] rdData,
  input  logic [7:0] blkCount,
  output dpStrobe_t strobe,
  output logic      sdaOe
);
  logic [1:0] sclSync, sdaSync;
  logic       sclD, sdaD;
  logic       sclS, sdaS;
  logic       sclRise, sclFall, startSeen, stopSeen;

  assign sclS = sclSync[1];
  assign sdaS = sdaSync[1];
  assign sclRise   = sclS & ~sclD;
  assign sclFall   = ~sclS & sclD;
  assign startSeen = sclS & sclD & sdaD & ~sdaS;
  assign stopSeen  = sclS & sclD & ~sdaD & sdaS;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclSync <= 2'b11;
      sdaSync <= 2'b11;
      sclD    <= 1'b1;
      sdaD    <= 1'b1;
    end else begin
      sclSync <= {sclSync[0], sclIn};
      sdaSync <= {sdaSync[0], sdaIn};
      sclD    <= sclS;
      sdaD    <= sdaS;
    end
  end

  busState_t  state;
  logic [3:0] bitCnt;
  logic [7:0] shifter, txByte;
  logic       ackSlot, hostSlot, hostNack, isRx;
  logic [2:0] bitPos;

  assign isRx   = (state == stAddr) || (state == stIndex) ||
                  (state == stCount) || (state == stWrData);
  assign bitPos = 3'd7 - bitCnt[2:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= stIdle;
      bitCnt   <= '0;
      shifter  <= '0;
      txByte   <= '0;
      ackSlot  <= 1'b0;
      hostSlot <= 1'b0;
      hostNack <= 1'b0;
      sdaOe    <= 1'b0;
      strobe   <= '0;
    end else begin
      strobe <= '0;
      if (startSeen || stopSeen) begin
        state    <= startSeen ? stAddr : stIdle;
        bitCnt   <= '0;
        ackSlot  <= 1'b0;
        hostSlot <= 1'b0;
        sdaOe    <= 1'b0;
      end else if (sclRise) begin
        if (state == stRdData) begin
          if (hostSlot) hostNack <= sdaS;
          else if (!ackSlot) bitCnt <= bitCnt + 4'd1;
        end else if (isRx && !ackSlot) begin
          shifter <= {shifter[6:0], sdaS};
          bitCnt  <= bitCnt + 4'd1;
        end
      end else if (sclFall) begin
        if (ackSlot) begin
          ackSlot <= 1'b0;
          bitCnt  <= '0;
          if (state == stRdData) begin
            txByte <= blkCount;
            sdaOe  <= ~blkCount[7];
          end else begin
            sdaOe <= 1'b0;
          end
        end else if (hostSlot) begin
          hostSlot <= 1'b0;
          bitCnt   <= '0;
          if (hostNack) begin
            state <= stIgnore;
            sdaOe <= 1'b0;
          end else begin
            txByte         <= rdData;
            sdaOe          <= ~rdData[7];
            strobe.advance <= 1'b1;
          end
        end else if (state == stRdData) begin
          if (bitCnt == 4'd8) begin
            sdaOe    <= 1'b0;
            hostSlot <= 1'b1;
          end else if (bitCnt != 4'd0) begin
            sdaOe <= ~txByte[bitPos];
          end
        end else if (isRx && bitCnt == 4'd8) begin
          ackSlot     <= 1'b1;
          sdaOe       <= 1'b1;
          strobe.data <= shifter;
          case (state)
            stAddr:
              if (shifter[7:1] == ADDR7) begin
                state <= shifter[0] ? stRdData : stIndex;
              end else begin
                state   <= stIgnore;
                ackSlot <= 1'b0;
                sdaOe   <= 1'b0;
              end
            stIndex: begin
              strobe.setIndex <= 1'b1;
              state           <= stCount;
            end
            stCount: begin
              strobe.setCount <= 1'b1;
              state           <= stWrData;
            end
            default: strobe.putByte <= 1'b1;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/smbRegs.sv
module smbRegs
  import smbPkg::*;
#(
  parameter int               NREG      = 8,
  parameter logic [NREG*8-1:0] RESET_VAL = 64'h0000_0000_00FF_FEFF,
  parameter logic [NREG*8-1:0] RW_MASK   = 64'h00F8_FFFF_FFFF_FFFF
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [NREG*8-1:0] roView,
  output logic [7:0]        rdData,
  output logic [7:0]        blkCount,
  output logic [NREG*8-1:0] ctlOut
);
  localparam int IW = (NREG > 1) ? $clog2(NREG) : 1;

  logic [7:0] idx, remain;
  logic [7:0] stored  [NREG];
  logic [7:0] viewArr [NREG];
  logic       commit;

  assign commit = strobe.putByte && (remain != 8'd0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      idx      <= '0;
      remain   <= '0;
      blkCount <= 8'(NREG);
    end else begin
      if (strobe.setIndex) idx <= strobe.data;
      if (strobe.setCount) begin
        blkCount <= strobe.data;
        remain   <= strobe.data;
      end
      if (commit) remain <= remain - 8'd1;
      if ((commit || strobe.advance) && idx != 8'hFF) idx <= idx + 8'd1;
    end
  end

  for (genvar g = 0; g < NREG; g++) begin : gByte
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) stored[g] <= RESET_VAL[g*8 +: 8];
      else if (commit && idx == 8'(g)) stored[g] <= strobe.data;
    end
    assign viewArr[g] = (stored[g] & RW_MASK[g*8 +: 8]) |
                        (roView[g*8 +: 8] & ~RW_MASK[g*8 +: 8]);
    assign ctlOut[g*8 +: 8] = viewArr[g];
  end

  assign rdData = (idx < 8'(NREG)) ? viewArr[idx[IW-1:0]] : 8'h00;
endmodule

// File: rtl/smbIndexTarget.sv
module smbIndexTarget
  import smbPkg::*;
#(
  parameter int               NREG      = 8,
  parameter logic [6:0]        ADDR7     = 7'h69,
  parameter logic [NREG*8-1:0] RESET_VAL = 64'h0000_0000_00FF_FEFF,
  parameter logic [NREG*8-1:0] RW_MASK   = 64'h00F8_FFFF_FFFF_FFFF
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  output logic              sdaOe,
  input  logic [2:0]        fsSel,
  input  logic [7:0]        devId,
  output logic [NREG*8-1:0] ctlOut
);
  dpStrobe_t         strobe;
  logic [7:0]        rdData, blkCount;
  logic [NREG*8-1:0] roView;

  always_comb begin
    roView = '0;
    roView[6*8 +: 3] = fsSel;
    roView[7*8 +: 8] = devId;
  end

  smbCtrl #(.ADDR7(ADDR7)) uCtrl (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .rdData(rdData), .blkCount(blkCount), .strobe(strobe), .sdaOe(sdaOe)
  );

  smbRegs #(.NREG(NREG), .RESET_VAL(RESET_VAL), .RW_MASK(RW_MASK)) uRegs (
    .clk(clk), .rstN(rstN), .strobe(strobe), .roView(roView),
    .rdData(rdData), .blkCount(blkCount), .ctlOut(ctlOut)
  );
endmodule

// File: rtl/smbIndexTargetChk.sv
module smbIndexTargetChk #(
  parameter int               NREG      = 8,
  parameter logic [NREG*8-1:0] RESET_VAL = 64'h0000_0000_00FF_FEFF
) (
  input logic              clk,
  input logic              rstN,
  input logic              sclIn,
  input logic              sdaOe,
  input logic [NREG*8-1:0] ctlOut
);
  localparam int LOWB = (NREG - 2) * 8;

  // R10: SDA is pulled low only while SCL is low
  a_r10_pull_scl_low: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdaOe) |-> !sclIn);

  // R10: SDA is released only while SCL is low
  a_r10_release_scl_low: assert property (@(posedge clk) disable iff (!rstN)
    $fell(sdaOe) |-> !sclIn);

  // R10, R9: writable register bytes change only while SCL is low
  a_r10_write_scl_low: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(ctlOut[LOWB-1:0]) |-> !sclIn);

  // R1: reset values are present and SDA is released on the first cycle out of reset
  a_r1_reset_state: assert property (@(posedge clk) disable iff (!rstN)
    $past(!rstN) |-> (ctlOut[LOWB-1:0] == RESET_VAL[LOWB-1:0]) && !sdaOe);
endmodule

bind smbIndexTarget smbIndexTargetChk #(.NREG(NREG), .RESET_VAL(RESET_VAL)) uChk (
  .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaOe(sdaOe), .ctlOut(ctlOut)
);

// File: tb/tb_smbIndexTarget.sv
module tb_smbIndexTarget;
  localparam int Q = 8;
  localparam logic [23:0] VECS [5] = '{
    24'h00_03_A5, 24'h03_03_3C, 24'h06_02_FF, 24'h01_05_5A, 24'h05_01_C3
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclDrv = 1'b1, sdaDrv = 1'b1;
  logic sdaOe, sdaWire;
  logic [2:0] fsSel = 3'b101;
  logic [7:0] devId = 8'h01;
  logic [63:0] ctlOut;
  int nChecks = 0, nErr = 0;
  bit done = 0;
  logic [7:0] model [8];
  logic [7:0] rdBuf [16];
  logic [7:0] rdCnt;

  always #5 clk = ~clk;
  assign sdaWire = sdaDrv & ~sdaOe;

  smbIndexTarget dut (
    .clk(clk), .rstN(rstN), .sclIn(sclDrv), .sdaIn(sdaWire), .sdaOe(sdaOe),
    .fsSel(fsSel), .devId(devId), .ctlOut(ctlOut)
  );

  function automatic logic [7:0] mask(input int i);
    return (i < 6) ? 8'hFF : (i == 6) ? 8'hF8 : 8'h00;
  endfunction
  function automatic logic [7:0] expByte(input int i);
    logic [7:0] ro;
    if (i > 7) return 8'h00;
    ro = (i == 6) ? {5'b0, fsSel} : (i == 7) ? devId : 8'h00;
    return (model[i] & mask(i)) | (ro & ~mask(i));
  endfunction
  function automatic logic [63:0] expView();
    logic [63:0] v;
    for (int i = 0; i < 8; i++) v[i*8 +: 8] = expByte(i);
    return v;
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic waitQ(); repeat (Q) @(negedge clk); endtask
  task automatic busStart(); sdaDrv = 1; sclDrv = 1; waitQ(); sdaDrv = 0; waitQ(); sclDrv = 0; waitQ(); endtask
  task automatic busRepStart(); sdaDrv = 1; waitQ(); sclDrv = 1; waitQ(); sdaDrv = 0; waitQ(); sclDrv = 0; waitQ(); endtask
  task automatic busStop(); sdaDrv = 0; waitQ(); sclDrv = 1; waitQ(); sdaDrv = 1; waitQ(); endtask
  task automatic busBit(input logic b, output logic s);
    sdaDrv = b; waitQ(); sclDrv = 1;
    repeat (Q/2) @(negedge clk); s = sdaWire;
    repeat (Q/2) @(negedge clk); sclDrv = 0;
  endtask
  task automatic busWrite(input logic [7:0] b, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) busBit(b[i], s);
    busBit(1'b1, s);
    ack = ~s;
  endtask
  task automatic busRead(input logic ackIt, output logic [7:0] b);
    logic s;
    for (int i = 7; i >= 0; i--) begin busBit(1'b1, s); b[i] = s; end
    busBit(~ackIt, s);
  endtask

  // block write of nSend bytes (seed based), counted acks; model follows R3/R5/R7
  task automatic blockWrite(input string tag, input logic [7:0] n, input logic [7:0] cnt,
                            input logic [7:0] seed, input int nSend, input bit doStop);
    logic ack; int acks;
    acks = 0;
    busStart();
    busWrite(8'hD2, ack); acks += ack;
    busWrite(n, ack);     acks += ack;
    busWrite(cnt, ack);   acks += ack;
    for (int k = 0; k < nSend; k++) begin
      busWrite(8'(seed + k * 59), ack); acks += ack;
      if (k < cnt && n + k < 8) model[n + k] = 8'(seed + k * 59);
    end
    chk({tag, " acks"}, 64'(acks), 64'(nSend + 3));
    if (doStop) busStop();
  endtask

  task automatic blockRead(input logic [7:0] n, input int nData);
    logic ack;
    busStart();
    busWrite(8'hD2, ack);
    busWrite(n, ack);
    busRepStart();
    busWrite(8'hD3, ack);
    busRead(nData != 0, rdCnt);
    for (int k = 0; k < nData; k++) busRead(k != nData - 1, rdBuf[k]);
    busStop();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nErr++; nChecks++;
      $display("FAIL watchdog actual hung expected done");
      $display("  CHECKS %0d ERRORS %0d", nChecks, nErr);
      $finish;
    end
  end

  initial begin
    logic ack;
    logic s;
    model = '{8'hFF, 8'hFE, 8'hFF, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00};
    repeat (4) @(negedge clk);
    rstN = 1;
    repeat (4) @(negedge clk);
    chk("R1 reset view", ctlOut, 64'h0105_0000_00FF_FEFF);
    chk("R1 sda released", 64'(sdaOe), 64'd0);

    blockRead(8'h00, 8);
    chk("R11 reset count", 64'(rdCnt), 64'd8);
    for (int k = 0; k < 8; k++) chk($sformatf("R4 R6 reset read %0d", k), 64'(rdBuf[k]), 64'(expByte(k)));

    foreach (VECS[v]) begin
      blockWrite($sformatf("R3 vec%0d", v), VECS[v][23:16], VECS[v][15:8], VECS[v][7:0],
                 int'(VECS[v][15:8]), 1'b1);
      chk($sformatf("R3 R6 vec%0d view", v), ctlOut, expView());
      blockRead(VECS[v][23:16], int'(VECS[v][15:8]));
      chk($sformatf("R11 vec%0d count", v), 64'(rdCnt), 64'(VECS[v][15:8]));
      for (int k = 0; k < int'(VECS[v][15:8]); k++)
        chk($sformatf("R4 vec%0d byte%0d", v, k), 64'(rdBuf[k]), 64'(expByte(VECS[v][23:16] + k)));
    end

    // R2: foreign address is not acknowledged, bus ignored
    busStart();
    busWrite(8'hA0, ack);
    chk("R2 foreign addr nack", 64'(ack), 64'd0);
    busWrite(8'h00, ack); busWrite(8'h01, ack); busWrite(8'h00, ack);
    chk("R2 ignored data nack", 64'(ack), 64'd0);
    busStop();
    chk("R2 view unchanged", ctlOut, expView());

    // R5: write above 7 ignored, read above 7 returns zero
    blockWrite("R5 high index", 8'd9, 8'd1, 8'h77, 1, 1'b1);
    chk("R5 view unchanged", ctlOut, expView());
    blockRead(8'd6, 4);
    chk("R5 read byte8", 64'(rdBuf[2]), 64'h00);
    chk("R5 read byte9", 64'(rdBuf[3]), 64'h00);
    chk("R6 read byte7", 64'(rdBuf[1]), 64'h01);

    // R7: extra bytes beyond count acked but not stored
    blockWrite("R7 overrun", 8'd4, 8'd1, 8'h11, 2, 1'b1);
    chk("R7 view", ctlOut, expView());

    // R9: stop mid-transfer keeps committed bytes
    blockWrite("R9 cut short", 8'd2, 8'd3, 8'h81, 1, 1'b1);
    chk("R9 byte2 kept", 64'(ctlOut[23:16]), 64'h81);
    chk("R9 view", ctlOut, expView());

    // R8: NACK after count releases SDA until next start
    blockWrite("R8 set count", 8'd0, 8'd2, 8'h00, 2, 1'b1);
    busStart();
    busWrite(8'hD2, ack); busWrite(8'd0, ack);
    busRepStart();
    busWrite(8'hD3, ack);
    busRead(1'b0, rdCnt);
    chk("R8 count", 64'(rdCnt), 64'd2);
    for (int k = 0; k < 9; k++) begin
      busBit(1'b1, s);
      chk($sformatf("R8 released bit%0d", k), 64'(s), 64'd1);
    end
    busStop();
    blockRead(8'd0, 2);
    chk("R8 recovers", 64'(rdBuf[1]), 64'(expByte(1)));

    repeat (10) @(negedge clk);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", nChecks, nErr);
    $finish;
  end
endmodule